// File: doc/BRIEF.md
# Page Program Data Buffer

This block stages the data bytes of a page-program transfer on a serial flash slave. The command decoder pulses a start strobe with the 24-bit start address once the address phase is over. It then hands over each received data byte with a strobe. When chip select rises, it reports that event together with a flag saying whether the rise fell on a whole-byte boundary. The buffer holds one page of data, indexed by column. It also keeps a bitmap of the columns that were actually loaded.

After a clean chip-select rise, the buffer presents the loaded columns to the array writer one pair at a time, lowest column first, under a ready/valid handshake. Each pair carries the page address, the column and the data byte, and the final pair is flagged. If the rise is off a byte boundary, the buffer throws the whole transfer away and raises a one-cycle abort pulse. If no byte was loaded, the rise produces neither a pair nor an abort. Array programming, busy timing and protection checks are handled by other blocks.

Top module: `page_prog_buf`

## Requirements
- R1: Every pair presented carries wr_page_o equal to bits 17..8 of the start address; bits 23..18 have no effect on any output.
- R2: The first data byte is stored at column start_addr_i[7:0]. Each later byte goes to the next column, and column 255 is followed by column 0 of the same page.
- R3: When more than 256 bytes are loaded, exactly 256 pairs are presented, and each holds the most recent byte loaded into its column.
- R4: When a column is loaded twice, its pair carries the later byte.
- R5: Only loaded columns are presented, each exactly once.
- R6: Pairs are presented in strictly ascending column order.
- R7: While wr_valid_o is high and wr_ready_i is low, wr_col_o, wr_data_o and wr_page_o hold their values in the next cycle, and a pair is consumed only in a cycle where both are high.
- R8: wr_last_o is high exactly on the final pair, and wr_valid_o is low in the cycle after that pair is consumed.
- R9: A chip-select rise with cs_aligned_i low makes abort_o high for one cycle, starting the cycle after the rise. No pair of that transfer is ever presented.
- R10: A chip-select rise with cs_aligned_i high and no bytes loaded presents no pair and gives no abort.
- R11: wr_valid_o stays low while bytes are being loaded, and it goes high in the cycle after an aligned chip-select rise that follows at least one byte.
- R12: During and right after reset, wr_valid_o, wr_last_o and abort_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of a page-program data phase |
| start_addr_i | input | 24 | Start address, sampled with start_i |
| byte_vld_i | input | 1 | A data byte is present on byte_i |
| byte_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | Chip select rose, ending the transfer |
| cs_aligned_i | input | 1 | The rise was on a whole-byte boundary |
| wr_valid_o | output | 1 | A column/data pair is offered to the writer |
| wr_ready_i | input | 1 | Writer accepts the offered pair |
| wr_page_o | output | 10 | Page address of the offered pair |
| wr_col_o | output | 8 | Column of the offered pair |
| wr_data_o | output | 8 | Data of the offered pair |
| wr_last_o | output | 1 | The offered pair is the final one |
| abort_o | output | 1 | One-cycle pulse: transfer discarded |

## Verification
The assertions rely on the decoder following the framing of one transfer. start_i arrives only while the buffer is idle. Byte strobes and the chip-select event come only after a start, and never in the same cycle. No new start arrives while pairs are still being drained. The bench keeps to this by running every scenario as a strict sequence: a start, the bytes one per cycle, then one chip-select event. A new start is issued only after the drain has completed or after an abort. Backpressure is applied only through wr_ready_i.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2
  } ppb_state_e;
endpackage

// File: rtl/ppb_ctrl.sv
module ppb_ctrl
  import ppb_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int PAGE_W = 10,
  localparam int USE_W = COL_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [USE_W-1:0]  start_addr_i,
  input  logic              byte_vld_i,
  input  logic              cs_rise_i,
  input  logic              cs_aligned_i,
  input  logic              wr_ready_i,
  input  logic              any_i,
  input  logic              single_i,
  output logic              wr_en_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic              clr_all_o,
  output logic              pop_o,
  output logic              offer_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              abort_o
);
  ppb_state_e state_q;
  logic [COL_W-1:0]  col_q;
  logic [PAGE_W-1:0] page_q;
  logic              abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      page_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          page_q  <= start_addr_i[USE_W-1:COL_W];
          col_q   <= start_addr_i[COL_W-1:0];
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          if (byte_vld_i) col_q <= col_q + 1'b1;
          if (cs_rise_i) begin
            if (!cs_aligned_i) begin
              abort_q <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= any_i ? ST_COMMIT : ST_IDLE;
            end
          end
        end
        ST_COMMIT: if (wr_ready_i && single_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en_o   = (state_q == ST_LOAD) && byte_vld_i;
  assign wr_col_o  = col_q;
  // fresh start and misaligned rise both discard the bitmap
  assign clr_all_o = ((state_q == ST_IDLE) && start_i) ||
                     ((state_q == ST_LOAD) && cs_rise_i && !cs_aligned_i);
  assign offer_o   = (state_q == ST_COMMIT) && any_i;
  assign pop_o     = offer_o && wr_ready_i;
  assign page_o    = page_q;
  assign abort_o   = abort_q;
endmodule

// File: rtl/ppb_store.sv
module ppb_store #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [COL_W-1:0]  wr_col_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_all_i,
  input  logic              pop_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DEPTH-1:0]  vmap_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vmap_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_col_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vmap_q <= '0;
    end else if (clr_all_i) begin
      vmap_q <= '0;
    end else begin
      if (wr_en_i) vmap_q[wr_col_i] <= 1'b1;
      if (pop_i)   vmap_q[rd_col_i] <= 1'b0;
    end
  end

  assign rd_data_o = mem_q[rd_col_i];
  assign vmap_o    = vmap_q;
endmodule

// File: rtl/ppb_pick.sv
module ppb_pick #(
  parameter int COL_W = 8,
  localparam int DEPTH = 1 << COL_W
) (
  input  logic [DEPTH-1:0] vmap_i,
  output logic             any_o,
  output logic             single_o,
  output logic [COL_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vmap_i[i]) idx_o = COL_W'(i);
    end
  end

  assign any_o    = |vmap_i;
  assign single_o = any_o && ((vmap_i & (vmap_i - 1'b1)) == '0);
endmodule

// File: rtl/page_prog_buf.sv
module page_prog_buf #(
  parameter int ADDR_W = 24,
  parameter int COL_W  = 8,
  parameter int PAGE_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              cs_rise_i,
  input  logic              cs_aligned_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [PAGE_W-1:0] wr_page_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_last_o,
  output logic              abort_o
);
  localparam int DEPTH = 1 << COL_W;
  localparam int USE_W = COL_W + PAGE_W;

  logic             wr_en, clr_all, pop, any, single, offer;
  logic [COL_W-1:0] ld_col, pick_col;
  logic [DEPTH-1:0] vmap;

  ppb_ctrl #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_addr_i (start_addr_i[USE_W-1:0]),
    .byte_vld_i   (byte_vld_i),
    .cs_rise_i    (cs_rise_i),
    .cs_aligned_i (cs_aligned_i),
    .wr_ready_i   (wr_ready_i),
    .any_i        (any),
    .single_i     (single),
    .wr_en_o      (wr_en),
    .wr_col_o     (ld_col),
    .clr_all_o    (clr_all),
    .pop_o        (pop),
    .offer_o      (offer),
    .page_o       (wr_page_o),
    .abort_o      (abort_o)
  );

  ppb_store #(.COL_W(COL_W), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_col_i  (ld_col),
    .wr_data_i (byte_i),
    .clr_all_i (clr_all),
    .pop_i     (pop),
    .rd_col_i  (pick_col),
    .rd_data_o (wr_data_o),
    .vmap_o    (vmap)
  );

  ppb_pick #(.COL_W(COL_W)) u_pick (
    .vmap_i   (vmap),
    .any_o    (any),
    .single_o (single),
    .idx_o    (pick_col)
  );

  assign wr_valid_o = offer;
  assign wr_col_o   = pick_col;
  assign wr_last_o  = offer && single;
endmodule

// File: rtl/ppb_chk.sv
module ppb_chk #(
  parameter int COL_W  = 8,
  parameter int PAGE_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_rise_i,
  input logic              cs_aligned_i,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [PAGE_W-1:0] wr_page_o,
  input logic [COL_W-1:0]  wr_col_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              wr_last_o,
  input logic              abort_o
);
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_col_o) &&
                                     $stable(wr_data_o) && $stable(wr_page_o))); // R7

  AST_ASCENDING_COLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_ready_i && !wr_last_o) |=>
      (wr_valid_o && (wr_col_o > $past(wr_col_o)))); // R6

  AST_LAST_ENDS_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_ready_i && wr_last_o) |=> !wr_valid_o); // R8

  AST_ABORT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(cs_rise_i && !cs_aligned_i)); // R9

  AST_ABORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (!wr_valid_o && !wr_last_o)); // R9

  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R9

  AST_LAST_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_last_o |-> wr_valid_o); // R8
endmodule

bind page_prog_buf ppb_chk #(.COL_W(COL_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_rise_i    (cs_rise_i),
  .cs_aligned_i (cs_aligned_i),
  .wr_valid_o   (wr_valid_o),
  .wr_ready_i   (wr_ready_i),
  .wr_page_o    (wr_page_o),
  .wr_col_o     (wr_col_o),
  .wr_data_o    (wr_data_o),
  .wr_last_o    (wr_last_o),
  .abort_o      (abort_o)
);

// File: tb/page_prog_buf_tb.sv
module page_prog_buf_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] start_addr_i = '0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        cs_rise_i = 1'b0;
  logic        cs_aligned_i = 1'b0;
  logic        wr_ready_i = 1'b0;
  logic        wr_valid_o, wr_last_o, abort_o;
  logic [9:0]  wr_page_o;
  logic [7:0]  wr_col_o, wr_data_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit fin = 0;

  // reference model of the page
  bit         m_vld [256];
  logic [7:0] m_dat [256];
  logic [7:0] m_col;
  logic [9:0] m_page;

  page_prog_buf u_dut (.*);

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !fin) begin
      fin = 1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic op_start(input logic [23:0] a);
    for (int c = 0; c < 256; c++) m_vld[c] = 0;
    m_col  = a[7:0];
    m_page = a[17:8];
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    m_dat[m_col] = d; m_vld[m_col] = 1; m_col = m_col + 8'd1;
    byte_vld_i = 1'b1; byte_i = d;
    @(negedge clk_i);
    byte_vld_i = 1'b0;
  endtask

  task automatic cs_up(input bit aligned);
    cs_rise_i = 1'b1; cs_aligned_i = aligned;
    @(negedge clk_i);
    cs_rise_i = 1'b0; cs_aligned_i = 1'b0;
  endtask

  // handshake all pairs, compare against the model; bp enables backpressure
  task automatic drain(input bit bp, input string tag);
    int exp_c [256];
    int exp_n = 0;
    int got = 0;
    int errs = 0;
    bit prev_stall = 0;
    logic [7:0] prev_col = '0;
    for (int c = 0; c < 256; c++) if (m_vld[c]) begin exp_c[exp_n] = c; exp_n++; end
    for (int cyc = 0; cyc < 3000 && got < exp_n; cyc++) begin
      wr_ready_i = bp ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (prev_stall && !(wr_valid_o && wr_col_o == prev_col)) begin
        chk(0, {"R7 hold under stall ", tag}, int'(wr_col_o), int'(prev_col));
        errs++;
      end
      prev_stall = wr_valid_o && !wr_ready_i;
      prev_col   = wr_col_o;
      if (wr_valid_o && wr_ready_i) begin
        if (wr_col_o != exp_c[got][7:0] || wr_data_o != m_dat[exp_c[got]] ||
            wr_page_o != m_page || wr_last_o != (got == exp_n - 1)) begin
          chk(0, {"R1/R2/R6/R8 pair ", tag},
              int'({wr_page_o, wr_col_o, wr_data_o, wr_last_o}),
              int'({m_page, exp_c[got][7:0], m_dat[exp_c[got]], got == exp_n - 1}));
          errs++;
        end
        got++;
      end
      @(negedge clk_i);
    end
    chk(errs == 0, {"R6 pairs match model ", tag}, errs, 0);
    chk(got == exp_n, {"R5 pair count ", tag}, got, exp_n);
    wr_ready_i = 1'b1;
    #1;
    chk(!wr_valid_o, {"R8 idle after last ", tag}, int'(wr_valid_o), 0);
    @(negedge clk_i);
    wr_ready_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(!wr_valid_o && !wr_last_o && !abort_o, "R12 in reset",
        int'({wr_valid_o, wr_last_o, abort_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!wr_valid_o && !wr_last_o && !abort_o, "R12 after reset",
        int'({wr_valid_o, wr_last_o, abort_o}), 0);
  endtask

  task automatic t_basic;
    op_start(24'hFC_1230);
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
    chk(!wr_valid_o, "R11 quiet while loading", int'(wr_valid_o), 0);
    cs_up(1'b1);
    chk(wr_valid_o && wr_col_o == 8'h30, "R11 offer after rise",
        int'({wr_valid_o, wr_col_o}), int'({1'b1, 8'h30}));
    chk(wr_page_o == 10'h012, "R1 page ignores high bits", int'(wr_page_o), 'h012);
    drain(1'b0, "basic");
  endtask

  task automatic t_wrap;
    op_start(24'h03_55F0);
    for (int i = 0; i < 32; i++) push(8'(i * 7 + 3));
    cs_up(1'b1);
    chk(wr_col_o == 8'h00 && wr_data_o == 8'(16 * 7 + 3), "R2 wrap to column 0",
        int'({wr_col_o, wr_data_o}), int'({8'h00, 8'(16 * 7 + 3)}));
    drain(1'b1, "wrap");
  endtask

  task automatic t_overflow;
    op_start(24'h01_2210);
    for (int i = 0; i < 300; i++) push(8'(i ^ 8'h5A));
    cs_up(1'b1);
    // column 0x10 last written by byte 256
    chk(wr_col_o == 8'h00 && wr_data_o == m_dat[0], "R3 last 256 kept",
        int'(wr_data_o), int'(m_dat[0]));
    drain(1'b0, "overflow");
  endtask

  task automatic t_overwrite;
    op_start(24'h00_0400);
    for (int i = 0; i < 258; i++) push(i < 256 ? 8'h11 : 8'hE0 + 8'(i));
    cs_up(1'b1);
    chk(wr_col_o == 8'h00 && wr_data_o == 8'hE0, "R4 later byte wins",
        int'(wr_data_o), 'hE0);
    drain(1'b1, "overwrite");
  endtask

  task automatic t_abort;
    op_start(24'h00_3300);
    for (int i = 0; i < 3; i++) push(8'h77);
    cs_up(1'b0);
    chk(abort_o && !wr_valid_o, "R9 abort pulse", int'({abort_o, wr_valid_o}), 2);
    @(negedge clk_i);
    chk(!abort_o, "R9 abort one cycle", int'(abort_o), 0);
    for (int i = 0; i < 4; i++) begin
      wr_ready_i = 1'b1;
      @(negedge clk_i);
      if (wr_valid_o) chk(0, "R9 discarded data presented", 1, 0);
    end
    chk(!wr_valid_o, "R9 nothing after abort", int'(wr_valid_o), 0);
    wr_ready_i = 1'b0;
    op_start(24'h00_4405);
    push(8'h3C);
    cs_up(1'b1);
    drain(1'b0, "after abort");
  endtask

  task automatic t_empty;
    op_start(24'h00_1200);
    cs_up(1'b1);
    chk(!wr_valid_o && !abort_o, "R10 empty rise", int'({wr_valid_o, abort_o}), 0);
    @(negedge clk_i);
    chk(!wr_valid_o && !abort_o, "R10 stays quiet", int'({wr_valid_o, abort_o}), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_overflow();
    t_overwrite();
    t_abort();
    t_empty();
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule